// File: doc/BRIEF.md
# Masked vector lane writeback unit

This block assembles the value written back to a 512-bit destination vector register from the per-lane results of an external lane function, such as a reciprocal-square-root approximator. It does two jobs. The first is to present the lane function with its inputs. Each 32-bit lane normally takes its own source element. When a scalar memory operand is broadcast, every lane takes element 0 instead.

The second job is to combine the returned results with the old destination contents. Each lane is written, merged or zeroed according to a lane mask and a masking mode. Every lane beyond the active vector length is cleared. The combined value is captured in an output register in the cycle the results arrive. A one-cycle valid pulse marks the new value.

The vector length select, mask, mode flags and old destination are sampled in the same cycle as the result beat (`res_valid` high). The operand path is purely combinational from `src_vec`, `bcast` and `src_mem`.

Top module: `vec_lane_wb`

## Requirements
- R1: `lane_opnd` equals `src_vec` lane for lane (lane j at bits 32j+31..32j) whenever `bcast` and `src_mem` are not both 1; this includes `bcast`=1 with `src_mem`=0.
- R2: When `bcast`=1 and `src_mem`=1, every 32-bit lane of `lane_opnd` equals `src_vec[31:0]`.
- R3: The active lane count is set by `vlen_sel`: 2'b00 gives 4 lanes (128 bits), 2'b01 gives 8 lanes (256 bits), 2'b10 gives 16 lanes (512 bits), and the spare code 2'b11 also gives 16 lanes.
- R4: An active lane whose mask bit is 1, or any active lane while `mask_en`=0, takes its `res_vec` lane.
- R5: While `mask_en`=0, the value of `lane_mask` has no effect on `dst_out`.
- R6: An active lane whose mask bit is 0 with `mask_en`=1 and `zero_mode`=0 (merging) takes its `old_dst` lane.
- R7: An active lane whose mask bit is 0 with `mask_en`=1 and `zero_mode`=1 (zeroing) becomes 0.
- R8: Every bit of `dst_out` from the active vector length up to bit 511 is 0, whatever the mask, mode, results and old contents.
- R9: `dst_out` is loaded at the clock edge where `res_valid`=1, and `dst_valid` is 1 for exactly the following cycle; while `res_valid`=0, `dst_out` holds its value.
- R10: Synchronous active-low reset clears `dst_valid` and `dst_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vlen_sel | input | 2 | Vector length code (00=128, 01=256, 10/11=512 bits) |
| lane_mask | input | 16 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | 1 when a mask is in use |
| zero_mode | input | 1 | 1 = zero masked-off lanes, 0 = merge old value |
| bcast | input | 1 | Broadcast request |
| src_mem | input | 1 | Source operand comes from memory |
| src_vec | input | 512 | Source vector |
| lane_opnd | output | 512 | Per-lane operands for the lane function |
| res_valid | input | 1 | Lane results and write controls valid this cycle |
| res_vec | input | 512 | Per-lane results from the lane function |
| old_dst | input | 512 | Current destination register contents |
| dst_valid | output | 1 | New destination value available |
| dst_out | output | 512 | New destination register value |

## Verification
The only state here is the output register and its valid flag. A wrong lane decision is therefore visible at `dst_out` in the cycle after the result beat. It shows up as a wrong lane pattern: merged data where zero was due, stale data above the vector length, or a masked lane that was written. A wrong valid flag or a missed load shows up as a pulse that is missing, stretched or misplaced, or as `dst_out` changing while no results arrive. The bench drives distinct data in every lane of the results, the old contents and the source, so a lane that is swapped or misrouted always produces a value that differs from the expected one.

// File: rtl/vlw_pkg.sv
// Package: shared codes for the masked vector lane writeback unit.
// Assumes a 2-bit vector length code; lane width and count are module parameters.
package vlw_pkg;
    typedef logic [1:0] vlen_t;
    localparam vlen_t VL_128 = 2'b00;
    localparam vlen_t VL_256 = 2'b01;
    localparam vlen_t VL_512 = 2'b10;
    localparam vlen_t VL_SPR = 2'b11;
endpackage

// File: rtl/vlw_opnd_sel.sv
// Operand selector: gives each lane its source element, or element 0 for
// every lane when a memory scalar is broadcast.
// Assumes src_vec is packed with lane j at bits [j*LANE_W +: LANE_W].
module vlw_opnd_sel #(
    parameter int LANE_W = 32,
    parameter int LANES  = 16
) (
    input  logic [LANE_W*LANES-1:0] src_vec,
    input  logic                    bcast,
    input  logic                    src_mem,
    output logic [LANE_W*LANES-1:0] lane_opnd
);
    logic use_elem0;

    // Broadcast applies only to a memory source (R2); otherwise lanes pass through (R1)
    assign use_elem0 = bcast & src_mem;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // Per-lane operand mux
        assign lane_opnd[j*LANE_W +: LANE_W] =
            use_elem0 ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/vlw_lane_ctl.sv
// Lane control: decodes the vector length into per-lane active flags and
// combines them with the mask into per-lane "take result" flags.
// Assumes the active lane count is BASE_LANES << vlen_sel, capped at LANES.
module vlw_lane_ctl #(
    parameter int LANES      = 16,
    parameter int BASE_LANES = 4
) (
    input  logic [1:0]       vlen_sel,
    input  logic [LANES-1:0] lane_mask,
    input  logic             mask_en,
    output logic [LANES-1:0] lane_active,
    output logic [LANES-1:0] lane_take
);
    localparam int LIM_W = $clog2(LANES) + 6;

    logic [LIM_W-1:0] lane_lim;
    logic [LANES-1:0] eff_mask;

    // Lane limit for the selected length; the spare code saturates via the compare (R3)
    assign lane_lim = LIM_W'(BASE_LANES) << vlen_sel;

    // Without a mask every lane is enabled and the mask bits are ignored (R5)
    assign eff_mask = mask_en ? lane_mask : {LANES{1'b1}};

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // A lane is active when its index is below the limit (R8)
        assign lane_active[j] = (LIM_W'(j) < lane_lim);
        // Result is taken for an active, enabled lane (R4)
        assign lane_take[j]   = lane_active[j] & eff_mask[j];
    end
endmodule

// File: rtl/vlw_lane_merge.sv
// Lane merge: forms the next destination value lane by lane from results,
// old contents or zero.
// Assumes lane_take implies lane_active.
module vlw_lane_merge #(
    parameter int LANE_W = 32,
    parameter int LANES  = 16
) (
    input  logic [LANES-1:0]        lane_active,
    input  logic [LANES-1:0]        lane_take,
    input  logic                    zero_mode,
    input  logic [LANE_W*LANES-1:0] res_vec,
    input  logic [LANE_W*LANES-1:0] old_dst,
    output logic [LANE_W*LANES-1:0] new_dst
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // Per-lane priority: beyond length, written, zeroed, merged
        always_comb begin
            if (!lane_active[j]) begin
                new_dst[j*LANE_W +: LANE_W] = '0;                          // R8
            end else if (lane_take[j]) begin
                new_dst[j*LANE_W +: LANE_W] = res_vec[j*LANE_W +: LANE_W]; // R4
            end else if (zero_mode) begin
                new_dst[j*LANE_W +: LANE_W] = '0;                          // R7
            end else begin
                new_dst[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W]; // R6
            end
        end
    end
endmodule

// File: rtl/vec_lane_wb.sv
// Masked vector lane writeback unit (top).
// Presents per-lane operands to an external lane function and registers the
// masked, length-trimmed destination value when the lane results arrive.
// Assumes all write controls and old_dst are valid in the res_valid cycle.
module vec_lane_wb #(
    parameter int LANE_W     = 32,
    parameter int MAX_LANES  = 16,
    parameter int BASE_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  vlen_sel,
    input  logic [MAX_LANES-1:0]        lane_mask,
    input  logic                        mask_en,
    input  logic                        zero_mode,
    input  logic                        bcast,
    input  logic                        src_mem,
    input  logic [LANE_W*MAX_LANES-1:0] src_vec,
    output logic [LANE_W*MAX_LANES-1:0] lane_opnd,
    input  logic                        res_valid,
    input  logic [LANE_W*MAX_LANES-1:0] res_vec,
    input  logic [LANE_W*MAX_LANES-1:0] old_dst,
    output logic                        dst_valid,
    output logic [LANE_W*MAX_LANES-1:0] dst_out
);
    localparam int VEC_W = LANE_W * MAX_LANES;

    logic [MAX_LANES-1:0] lane_active;
    logic [MAX_LANES-1:0] lane_take;
    logic [VEC_W-1:0]     new_dst;

    vlw_opnd_sel #(.LANE_W(LANE_W), .LANES(MAX_LANES)) u_opnd (
        .src_vec   (src_vec),
        .bcast     (bcast),
        .src_mem   (src_mem),
        .lane_opnd (lane_opnd)
    );

    vlw_lane_ctl #(.LANES(MAX_LANES), .BASE_LANES(BASE_LANES)) u_ctl (
        .vlen_sel    (vlen_sel),
        .lane_mask   (lane_mask),
        .mask_en     (mask_en),
        .lane_active (lane_active),
        .lane_take   (lane_take)
    );

    vlw_lane_merge #(.LANE_W(LANE_W), .LANES(MAX_LANES)) u_merge (
        .lane_active (lane_active),
        .lane_take   (lane_take),
        .zero_mode   (zero_mode),
        .res_vec     (res_vec),
        .old_dst     (old_dst),
        .new_dst     (new_dst)
    );

    // Output register: load on the result beat, pulse valid for one cycle (R9, R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_valid <= 1'b0;
            dst_out   <= '0;
        end else begin
            dst_valid <= res_valid;
            if (res_valid) begin
                dst_out <= new_dst;
            end
        end
    end
endmodule

// File: rtl/vec_lane_wb_chk.sv
// Checker: temporal properties of the writeback unit, bound to the top.
// Assumes the default reset polarity (active low, synchronous).
module vec_lane_wb_chk
    import vlw_pkg::*;
#(
    parameter int LANE_W     = 32,
    parameter int MAX_LANES  = 16,
    parameter int BASE_LANES = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  vlen_sel,
    input logic [MAX_LANES-1:0]        lane_mask,
    input logic                        mask_en,
    input logic                        zero_mode,
    input logic                        bcast,
    input logic                        src_mem,
    input logic [LANE_W*MAX_LANES-1:0] src_vec,
    input logic [LANE_W*MAX_LANES-1:0] lane_opnd,
    input logic                        res_valid,
    input logic [LANE_W*MAX_LANES-1:0] res_vec,
    input logic [LANE_W*MAX_LANES-1:0] old_dst,
    input logic                        dst_valid,
    input logic [LANE_W*MAX_LANES-1:0] dst_out
);
    // R1
    passthru_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bcast && src_mem) |-> lane_opnd == src_vec);

    // R2
    bcast_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast && src_mem) |-> lane_opnd == {MAX_LANES{src_vec[LANE_W-1:0]}});

    // R4
    nomask_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !mask_en && vlen_sel == VL_512) |=> dst_out == $past(res_vec));

    // R6
    merge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mask_en && !zero_mode && lane_mask == '0 && vlen_sel == VL_512)
        |=> dst_out == $past(old_dst));

    // R7
    zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mask_en && zero_mode && lane_mask == '0) |=> dst_out == '0);

    // R8
    tail128_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && vlen_sel == VL_128) |=> (dst_out >> (BASE_LANES*LANE_W)) == '0);

    // R8
    tail256_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && vlen_sel == VL_256) |=> (dst_out >> (2*BASE_LANES*LANE_W)) == '0);

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> dst_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !dst_valid);

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(dst_out));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!dst_valid && dst_out == '0));
endmodule

bind vec_lane_wb vec_lane_wb_chk #(
    .LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .BASE_LANES(BASE_LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vlen_sel(vlen_sel), .lane_mask(lane_mask),
    .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast), .src_mem(src_mem),
    .src_vec(src_vec), .lane_opnd(lane_opnd), .res_valid(res_valid),
    .res_vec(res_vec), .old_dst(old_dst), .dst_valid(dst_valid), .dst_out(dst_out)
);

// File: tb/vec_lane_wb_test.sv
// Directed bench for the writeback unit: one task per scenario.
module vec_lane_wb_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   vlen_sel = 2'b00;
    logic [15:0]  lane_mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast = 1'b0;
    logic         src_mem = 1'b0;
    logic [511:0] src_vec = '0;
    logic [511:0] lane_opnd;
    logic         res_valid = 1'b0;
    logic [511:0] res_vec = '0;
    logic [511:0] old_dst = '0;
    logic         dst_valid;
    logic [511:0] dst_out;

    int n_chk = 0;
    int n_fail = 0;

    vec_lane_wb uut (
        .clk(clk), .rst_n(rst_n), .vlen_sel(vlen_sel), .lane_mask(lane_mask),
        .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast), .src_mem(src_mem),
        .src_vec(src_vec), .lane_opnd(lane_opnd), .res_valid(res_valid),
        .res_vec(res_vec), .old_dst(old_dst), .dst_valid(dst_valid), .dst_out(dst_out)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic [511:0] fill(input logic [31:0] seed);
        logic [511:0] v;
        for (int j = 0; j < 16; j++) v[j*32 +: 32] = seed ^ (32'h0101_0101 * j) ^ (j << 28);
        return v;
    endfunction

    // Expected writeback value, written from R3, R4, R6, R7 and R8
    function automatic logic [511:0] expect_wb(input logic [1:0] vl, input logic [15:0] m,
                                               input logic men, input logic zm,
                                               input logic [511:0] res, input logic [511:0] old);
        logic [511:0] v;
        int nact;
        nact = (vl == 2'b00) ? 4 : (vl == 2'b01) ? 8 : 16;
        for (int j = 0; j < 16; j++) begin
            if (j >= nact)          v[j*32 +: 32] = '0;
            else if (!men || m[j])  v[j*32 +: 32] = res[j*32 +: 32];
            else if (zm)            v[j*32 +: 32] = '0;
            else                    v[j*32 +: 32] = old[j*32 +: 32];
        end
        return v;
    endfunction

    task automatic chk_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One result beat, then check the registered output and valid pulse
    task automatic beat(input string tag, input logic [1:0] vl, input logic [15:0] m,
                        input logic men, input logic zm);
        logic [511:0] exp;
        @(negedge clk);
        vlen_sel = vl; lane_mask = m; mask_en = men; zero_mode = zm;
        res_vec = fill(32'hA000_0011 ^ {16'h0, m}); old_dst = fill(32'h5C00_0022);
        exp = expect_wb(vl, m, men, zm, res_vec, old_dst);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        chk_bit({tag, " R9 valid pulse"}, dst_valid, 1'b1);
        chk_vec(tag, dst_out, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_bit("R10 reset valid", dst_valid, 1'b0);
        chk_vec("R10 reset data", dst_out, '0);
    endtask

    task automatic t_operands();
        @(negedge clk);
        src_vec = fill(32'h1234_5678);
        bcast = 1'b0; src_mem = 1'b0; #1;
        chk_vec("R1 no broadcast", lane_opnd, src_vec);
        bcast = 1'b0; src_mem = 1'b1; #1;
        chk_vec("R1 memory, no broadcast", lane_opnd, src_vec);
        bcast = 1'b1; src_mem = 1'b0; #1;
        chk_vec("R1 broadcast from register ignored", lane_opnd, src_vec);
        bcast = 1'b1; src_mem = 1'b1; #1;
        chk_vec("R2 broadcast element 0", lane_opnd, {16{src_vec[31:0]}});
        bcast = 1'b0; src_mem = 1'b0;
    endtask

    task automatic t_nomask();
        logic [511:0] first;
        beat("R4 unmasked 512", 2'b10, 16'h0000, 1'b0, 1'b0);
        chk_vec("R4 unmasked equals results", dst_out, res_vec);
        first = dst_out;
        @(negedge clk);
        vlen_sel = 2'b10; lane_mask = 16'hFFFF; mask_en = 1'b0;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        chk_vec("R5 mask bits ignored without mask", dst_out, first);
    endtask

    task automatic t_merge();
        beat("R6 merging 512", 2'b10, 16'hA5C3, 1'b1, 1'b0);
        beat("R6 merging all off", 2'b10, 16'h0000, 1'b1, 1'b0);
        chk_vec("R6 all lanes keep old", dst_out, old_dst);
    endtask

    task automatic t_zero();
        beat("R7 zeroing 512", 2'b10, 16'hA5C3, 1'b1, 1'b1);
        beat("R7 zeroing all off", 2'b10, 16'h0000, 1'b1, 1'b1);
        chk_vec("R7 all lanes zero", dst_out, '0);
    endtask

    task automatic t_lengths();
        beat("R3 R8 length 128 unmasked", 2'b00, 16'hFFFF, 1'b0, 1'b0);
        chk_vec("R8 upper 384 bits zero", dst_out >> 128, '0);
        beat("R3 R8 length 256 merging", 2'b01, 16'hFFF0, 1'b1, 1'b0);
        beat("R8 length 256 zeroing", 2'b01, 16'h0F3C, 1'b1, 1'b1);
        beat("R3 spare code is 512", 2'b11, 16'h0000, 1'b0, 1'b0);
        chk_vec("R3 spare code full width", dst_out, res_vec);
    endtask

    task automatic t_hold();
        logic [511:0] kept;
        kept = dst_out;
        @(negedge clk);
        chk_bit("R9 valid drops after one cycle", dst_valid, 1'b0);
        vlen_sel = 2'b10; mask_en = 1'b0;
        res_vec = fill(32'hDEAD_0000); old_dst = fill(32'hBEEF_0000);
        repeat (3) @(negedge clk);
        chk_vec("R9 output holds without results", dst_out, kept);
        chk_bit("R9 no valid without results", dst_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_operands();
        t_nomask();
        t_merge();
        t_zero();
        t_lengths();
        t_hold();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule